// File: doc/BRIEF.md
# Counted I2C Master Transfer Sequencer

This block sequences a master-side I2C transfer at byte level. It has no pins of its own on the wire. It drives an abstract master port that understands four operations: start with an address and a direction, send one byte and report the acknowledge, receive one byte, and stop. Host logic programs a 16-bit control word and a byte count. It then feeds or drains a four-byte staging buffer. The sequencer moves bytes between that buffer and the port, counts them down, and raises status flags.

Two transfer styles are offered. In counted mode the programmed count decides when the transfer ends. The sequencer then either issues a stop by itself or hands control back to the host by raising access-ready. In repeat mode the count plays no part: the sequencer keeps the buffer empty (transmit) or full (receive) until the host asks for a stop. Every port operation waits for its response before the next one is issued. Data moves only while the port reports the bus as busy.

Top module: `i2cXferSeq`

## Requirements
- R1: The control word uses these bit positions: enable 15, master 10, direction 9 (1 = transmit), ten-bit-address 8, repeat 2, stop 1, start 0. With the sequencer idle, a stored control word that has start, enable and master set and ten-bit-address clear issues a START operation (opKind 0) with opRead equal to the inverse of bit 9. The same step clears bit 0 and empties the staging buffer.
- R2: If a START is answered without acknowledge, nackFlag is set, bit 1 is cleared, and no data operation follows. An acknowledged START loads workCount from the programmed count.
- R3: In counted transmit (bit 2 clear, bit 9 set), buffered bytes are sent oldest first as SEND operations (opKind 1) while workCount is non-zero. workCount drops by one per acknowledged byte. txReady is high while workCount is non-zero.
- R4: A SEND answered without acknowledge ends the data phase. It sets nackFlag, clears txReady and clears bit 1, so no STOP is issued.
- R5: In counted receive (bit 9 clear), RECV operations (opKind 2) are issued while workCount is non-zero and the buffer holds fewer than 4 bytes, each one decrementing workCount. rxReady is high whenever the buffer is non-empty. rxHead presents the oldest byte, and rxPop removes it.
- R6: When workCount is zero and bit 1 is set, a STOP operation (opKind 3) is issued. After it, bit 1 is cleared and workCount is reloaded from the programmed count. Pending transmit bytes are discarded, and accessReady is not raised.
- R7: When workCount is zero and bit 1 is clear, accessReady is set and bit 10 is cleared, with no STOP.
- R8: In repeat mode workCount is never decremented. Transmit sends every buffered byte and raises txReady once the buffer is empty. Receive fills the buffer to exactly 4 bytes and then raises rxReady. Setting bit 1 issues a STOP at once.
- R9: A control write stores only the bits of mask 0xCF87. With bit 8 set, no START is issued.
- R10: With LEGACY_RESET set, a control write with bit 15 clear returns the control word, count, flags and buffer to their reset values.
- R11: No SEND or RECV operation is issued while busBusy is low.
- R12: An issued operation holds opValid and opKind until opDone. The buffer never holds more than 4 bytes, and no SEND is issued from an empty buffer.
- R13: After reset the control word, workCount, flags and buffer fill are zero and opValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 16 | Control word write value |
| ctrlQ | output | 16 | Current control word |
| cntWrEn | input | 1 | Byte count write strobe |
| cntWrData | input | CNT_W (16) | Programmed byte count |
| workCount | output | CNT_W (16) | Working (remaining) byte count |
| slaveAddr | input | ADDR_W (7) | Target address used by START |
| txPush | input | 1 | Append txByte to the staging buffer |
| txByte | input | 8 | Byte to transmit |
| rxPop | input | 1 | Remove the oldest buffered byte |
| rxHead | output | 8 | Oldest buffered byte |
| bufFill | output | FILL_W (3) | Number of buffered bytes |
| flagClr | input | 2 | Clear nackFlag (bit 0) and accessReady (bit 1) |
| txReady | output | 1 | Sequencer wants transmit data |
| rxReady | output | 1 | Received data available |
| accessReady | output | 1 | Counted transfer finished without stop |
| nackFlag | output | 1 | Acknowledge missing on START or SEND |
| busBusy | input | 1 | Port reports the bus as owned |
| opValid | output | 1 | Port operation request |
| opKind | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| opAddr | output | ADDR_W (7) | Address for START |
| opRead | output | 1 | Direction for START, 1 = read |
| opTxByte | output | 8 | Byte for SEND |
| opDone | input | 1 | Port response strobe |
| opAck | input | 1 | Acknowledge received with the response |
| opRxByte | input | 8 | Byte returned by RECV |

## Verification
The assertions watch the per-cycle rules on every cycle. They check that a requested operation stays unchanged until answered, and that the buffer stays within four bytes and is never sent from when empty. They check that data operations begin only after a cycle with busBusy high, that an acknowledged counted SEND takes exactly one off workCount, that a NACK always leaves the stop bit clear, and that accessReady rises only with the count at zero. Only the bench scenarios can show end-to-end results. These include the byte order on the wire and out of rxHead, where a NACK lands for each byte position, the choice between STOP and access-ready, the reload of the count, the repeat-mode fill and drain levels, the control mask and the legacy reset.

// File: rtl/i2cSeqPkg.sv
package i2cSeqPkg;
  localparam int BIT_EN  = 15;
  localparam int BIT_MST = 10;
  localparam int BIT_TRX = 9;
  localparam int BIT_XA  = 8;
  localparam int BIT_RM  = 2;
  localparam int BIT_STP = 1;
  localparam int BIT_STT = 0;
  localparam logic [15:0] CTRL_KEEP = 16'hCF87;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } opKind_e;

  // strobes from the sequencer control to the staging buffer
  typedef struct packed {
    logic flush;
    logic shiftOut;
    logic appendRx;
  } bufStrobe_t;
endpackage

// File: rtl/i2cSeqBuf.sv
module i2cSeqBuf import i2cSeqPkg::*; #(
  parameter int DEPTH  = 4,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobe,
  input  logic              hostPush,
  input  logic [7:0]        hostByte,
  input  logic              hostPop,
  input  logic [7:0]        rxIn,
  output logic [FILL_W-1:0] fill,
  output logic [7:0]        head
);
  logic [7:0]        mem    [DEPTH];
  logic [7:0]        nxtMem [DEPTH];
  logic [FILL_W-1:0] nxtFill;
  logic              doShift, doApp;
  logic [7:0]        appByte;

  always_comb begin
    doShift = strobe.shiftOut || (hostPop && fill != '0);
    doApp   = strobe.appendRx || hostPush;
    appByte = strobe.appendRx ? rxIn : hostByte;
    nxtMem  = mem;
    nxtFill = fill;
    if (doShift) begin
      for (int i = 0; i < DEPTH - 1; i++) nxtMem[i] = mem[i+1];
      nxtMem[DEPTH-1] = '0;
      nxtFill = fill - FILL_W'(1);
    end
    if (doApp && nxtFill < FILL_W'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (FILL_W'(i) == nxtFill) nxtMem[i] = appByte;
      nxtFill = nxtFill + FILL_W'(1);
    end
    if (strobe.flush) begin
      for (int i = 0; i < DEPTH; i++) nxtMem[i] = '0;
      nxtFill = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      fill <= '0;
    end else begin
      mem  <= nxtMem;
      fill <= nxtFill;
    end
  end

  assign head = mem[0];
endmodule

// File: rtl/i2cSeqCtrl.sv
module i2cSeqCtrl import i2cSeqPkg::*; #(
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 4,
  parameter int FILL_W = $clog2(DEPTH + 1),
  parameter bit LEGACY_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [15:0]       ctrlWrData,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic [1:0]        flagClr,
  input  logic              busBusy,
  input  logic [FILL_W-1:0] fill,
  input  logic              opDone,
  input  logic              opAck,
  output logic [15:0]       ctrlQ,
  output logic [CNT_W-1:0]  workCount,
  output logic              txReady,
  output logic              rxReady,
  output logic              accessReady,
  output logic              nackFlag,
  output logic              opValid,
  output logic [1:0]        opKind,
  output logic              opRead,
  output bufStrobe_t        strobe
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_RUN, S_SEND, S_RECV, S_STOP} seqState_e;

  seqState_e        state, stateN;
  logic [15:0]      ctrlN;
  logic [CNT_W-1:0] countQ, workQ, workN;
  logic             nackQ, nackN, ardyQ, ardyN, txRdyQ, txRdyN;
  logic             softReset, bufEmpty, bufFull;

  assign softReset = LEGACY_RESET && ctrlWrEn && !ctrlWrData[BIT_EN];
  assign bufEmpty  = (fill == '0);
  assign bufFull   = (fill >= FILL_W'(DEPTH));

  always_comb begin
    ctrlN  = ctrlWrEn ? (ctrlWrData & CTRL_KEEP) : ctrlQ;
    stateN = state;
    workN  = workQ;
    nackN  = nackQ & ~flagClr[0];
    ardyN  = ardyQ & ~flagClr[1];
    txRdyN = txRdyQ;
    strobe = '0;
    case (state)
      S_IDLE:
        if (ctrlQ[BIT_STT] && ctrlQ[BIT_EN] && ctrlQ[BIT_MST] && !ctrlQ[BIT_XA]) begin
          ctrlN[BIT_STT] = 1'b0;
          strobe.flush   = 1'b1;
          txRdyN         = 1'b0;
          stateN         = S_START;
        end
      S_START:
        if (opDone) begin
          if (!opAck) begin
            nackN          = 1'b1;
            ctrlN[BIT_STP] = 1'b0;
            stateN         = S_IDLE;
          end else begin
            workN  = countQ;
            stateN = S_RUN;
          end
        end
      S_RUN:
        if (busBusy) begin
          if (ctrlQ[BIT_RM]) begin
            if (ctrlQ[BIT_STP]) stateN = S_STOP;
            else if (ctrlQ[BIT_TRX]) begin
              txRdyN = bufEmpty;
              if (!bufEmpty) stateN = S_SEND;
            end else if (!bufFull) stateN = S_RECV;
          end else if (workQ == '0) begin
            txRdyN = 1'b0;
            if (ctrlQ[BIT_STP]) stateN = S_STOP;
            else begin
              ardyN          = 1'b1;
              ctrlN[BIT_MST] = 1'b0;
              stateN         = S_IDLE;
            end
          end else if (ctrlQ[BIT_TRX]) begin
            txRdyN = 1'b1;
            if (!bufEmpty) stateN = S_SEND;
          end else if (!bufFull) stateN = S_RECV;
        end
      S_SEND:
        if (opDone) begin
          strobe.shiftOut = 1'b1;
          if (opAck) begin
            if (!ctrlQ[BIT_RM]) workN = workQ - CNT_W'(1);
            stateN = S_RUN;
          end else begin
            nackN          = 1'b1;
            txRdyN         = 1'b0;
            ctrlN[BIT_STP] = 1'b0;
            stateN         = S_IDLE;
          end
        end
      S_RECV:
        if (opDone) begin
          strobe.appendRx = 1'b1;
          if (!ctrlQ[BIT_RM]) workN = workQ - CNT_W'(1);
          stateN = S_RUN;
        end
      S_STOP:
        if (opDone) begin
          ctrlN[BIT_STP] = 1'b0;
          workN          = countQ;
          txRdyN         = 1'b0;
          strobe.flush   = ctrlQ[BIT_TRX];
          stateN         = S_IDLE;
        end
      default: stateN = S_IDLE;
    endcase
    if (softReset) strobe.flush = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      ctrlQ  <= '0;
      countQ <= '0;
      workQ  <= '0;
      nackQ  <= 1'b0;
      ardyQ  <= 1'b0;
      txRdyQ <= 1'b0;
    end else if (softReset) begin
      state  <= S_IDLE;
      ctrlQ  <= '0;
      countQ <= '0;
      workQ  <= '0;
      nackQ  <= 1'b0;
      ardyQ  <= 1'b0;
      txRdyQ <= 1'b0;
    end else begin
      state  <= stateN;
      ctrlQ  <= ctrlN;
      countQ <= cntWrEn ? cntWrData : countQ;
      workQ  <= workN;
      nackQ  <= nackN;
      ardyQ  <= ardyN;
      txRdyQ <= txRdyN;
    end
  end

  always_comb begin
    opValid = 1'b1;
    opKind  = OP_START;
    case (state)
      S_START: opKind = OP_START;
      S_SEND:  opKind = OP_SEND;
      S_RECV:  opKind = OP_RECV;
      S_STOP:  opKind = OP_STOP;
      default: opValid = 1'b0;
    endcase
  end

  assign opRead      = ~ctrlQ[BIT_TRX];
  assign workCount   = workQ;
  assign txReady     = txRdyQ;
  assign accessReady = ardyQ;
  assign nackFlag    = nackQ;
  assign rxReady     = !ctrlQ[BIT_TRX] && (ctrlQ[BIT_RM] ? bufFull : !bufEmpty);
endmodule

// File: rtl/i2cXferSeq.sv
module i2cXferSeq import i2cSeqPkg::*; #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 7,
  parameter int DEPTH  = 4,
  parameter bit LEGACY_RESET = 1'b1,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [15:0]       ctrlWrData,
  output logic [15:0]       ctrlQ,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  output logic [CNT_W-1:0]  workCount,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic              txPush,
  input  logic [7:0]        txByte,
  input  logic              rxPop,
  output logic [7:0]        rxHead,
  output logic [FILL_W-1:0] bufFill,
  input  logic [1:0]        flagClr,
  output logic              txReady,
  output logic              rxReady,
  output logic              accessReady,
  output logic              nackFlag,
  input  logic              busBusy,
  output logic              opValid,
  output logic [1:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic              opRead,
  output logic [7:0]        opTxByte,
  input  logic              opDone,
  input  logic              opAck,
  input  logic [7:0]        opRxByte
);
  bufStrobe_t bufStb;

  i2cSeqCtrl #(.CNT_W(CNT_W), .DEPTH(DEPTH), .FILL_W(FILL_W), .LEGACY_RESET(LEGACY_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .flagClr(flagClr), .busBusy(busBusy),
    .fill(bufFill), .opDone(opDone), .opAck(opAck), .ctrlQ(ctrlQ), .workCount(workCount),
    .txReady(txReady), .rxReady(rxReady), .accessReady(accessReady), .nackFlag(nackFlag),
    .opValid(opValid), .opKind(opKind), .opRead(opRead), .strobe(bufStb)
  );

  i2cSeqBuf #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_buf (
    .clk(clk), .rstN(rstN), .strobe(bufStb), .hostPush(txPush), .hostByte(txByte),
    .hostPop(rxPop), .rxIn(opRxByte), .fill(bufFill), .head(rxHead)
  );

  assign opAddr   = slaveAddr;
  assign opTxByte = rxHead;
endmodule

// File: rtl/i2cSeqChecker.sv
module i2cSeqChecker import i2cSeqPkg::*; #(
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 4,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opKind,
  input logic              opDone,
  input logic              opAck,
  input logic [FILL_W-1:0] bufFill,
  input logic [2:0]        ctrlLow,
  input logic [CNT_W-1:0]  workCount,
  input logic              nackFlag,
  input logic              accessReady,
  input logic              busBusy
);
  assert_op_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opDone) |=> (opValid && $stable(opKind)));

  assert_fill_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    bufFill <= FILL_W'(DEPTH));

  assert_no_empty_send_R12: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == OP_SEND) |-> bufFill != '0);

  assert_count_dec_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opDone && opAck && opKind == OP_SEND && !ctrlLow[BIT_RM])
      |=> workCount == $past(workCount) - CNT_W'(1));

  assert_nack_cancels_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nackFlag) |-> !ctrlLow[BIT_STP]);

  assert_ardy_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accessReady) |-> workCount == '0);

  assert_busy_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(opValid) && (opKind == OP_SEND || opKind == OP_RECV)) |-> $past(busBusy));

  assert_start_cleared_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opValid && opKind == OP_START) |-> !ctrlLow[BIT_STT]);
endmodule

bind i2cXferSeq i2cSeqChecker #(.CNT_W(CNT_W), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_seqChecker (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opDone(opDone),
  .opAck(opAck), .bufFill(bufFill), .ctrlLow(ctrlQ[2:0]), .workCount(workCount),
  .nackFlag(nackFlag), .accessReady(accessReady), .busBusy(busBusy)
);

// File: tb/test_i2cXferSeq.sv
`timescale 1ns/1ps
module test_i2cXferSeq;
  localparam logic [15:0] EN = 16'h8000, MST = 16'h0400, TRX = 16'h0200,
                          RM = 16'h0004, STP = 16'h0002, STT = 16'h0001;

  logic clk = 0, rstN = 0;
  always #2 clk = ~clk;

  logic ctrlWrEn = 0, cntWrEn = 0, txPush = 0, rxPop = 0, opDone = 0, opAck = 0;
  logic [15:0] ctrlWrData = 0, cntWrData = 0;
  logic [7:0]  txByte = 0, opRxByte = 0;
  logic [1:0]  flagClr = 0;
  logic [6:0]  slaveAddr = 7'h2A;
  logic [15:0] ctrlQ, workCount;
  logic [7:0]  rxHead, opTxByte;
  logic [2:0]  bufFill;
  logic [1:0]  opKind;
  logic [6:0]  opAddr;
  logic txReady, rxReady, accessReady, nackFlag, opValid, opRead;
  logic modelBusy = 0, gate = 0, startNak = 0, startRead = 0;
  wire  busBusy = modelBusy & ~gate;

  int sentCnt = 0, recvCnt = 0, stopCnt = 0, startCnt = 0, nakAt = 99;
  logic [7:0] sentLog [16];
  int checkCnt = 0, failCnt = 0;

  i2cXferSeq i_i2cXferSeq (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlQ(ctrlQ),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .workCount(workCount), .slaveAddr(slaveAddr),
    .txPush(txPush), .txByte(txByte), .rxPop(rxPop), .rxHead(rxHead), .bufFill(bufFill),
    .flagClr(flagClr), .txReady(txReady), .rxReady(rxReady), .accessReady(accessReady),
    .nackFlag(nackFlag), .busBusy(busBusy), .opValid(opValid), .opKind(opKind),
    .opAddr(opAddr), .opRead(opRead), .opTxByte(opTxByte), .opDone(opDone),
    .opAck(opAck), .opRxByte(opRxByte)
  );

  // byte-level port model: answers each request one cycle after it appears
  always @(negedge clk) begin
    if (opDone) opDone = 0;
    else if (opValid) begin
      opDone = 1;
      case (opKind)
        2'd0: begin opAck = !startNak; startRead = opRead; startCnt++; if (!startNak) modelBusy = 1; end
        2'd1: begin if (sentCnt < 16) sentLog[sentCnt] = opTxByte; opAck = (sentCnt != nakAt); sentCnt++; end
        2'd2: begin opAck = 1; opRxByte = 8'hA0 + 8'(recvCnt); recvCnt++; end
        default: begin opAck = 1; modelBusy = 0; stopCnt++; end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  task automatic ctrlWr(input logic [15:0] v);
    @(negedge clk); ctrlWrEn = 1; ctrlWrData = v;
    @(negedge clk); ctrlWrEn = 0;
  endtask

  task automatic cntWr(input logic [15:0] v);
    @(negedge clk); cntWrEn = 1; cntWrData = v;
    @(negedge clk); cntWrEn = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); txPush = 1; txByte = b;
    @(negedge clk); txPush = 0;
  endtask

  task automatic clrFlags();
    @(negedge clk); flagClr = 2'b11;
    @(negedge clk); flagClr = 2'b00;
  endtask

  task automatic clearLog();
    sentCnt = 0; recvCnt = 0; stopCnt = 0; startCnt = 0; nakAt = 99;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R13 reset state
    check(ctrlQ == 0 && workCount == 0, "R13 control/count after reset", int'(ctrlQ), 0);
    check({nackFlag, accessReady, txReady, rxReady} == 0, "R13 flags after reset",
          int'({nackFlag, accessReady, txReady, rxReady}), 0);
    check(bufFill == 0 && !opValid, "R13 buffer and port idle", int'(bufFill), 0);

    // counted transmit sweep over count and stop choice
    for (int stp = 0; stp < 2; stp++) begin
      for (int n = 0; n <= 4; n++) begin
        clearLog(); clrFlags(); cntWr(16'(n));
        ctrlWr(EN | MST | TRX | STT | (stp != 0 ? STP : 16'h0));
        for (int b = 0; b < n; b++) push(8'(16 * n + b + 1));
        for (int k = 0; k < 300 && !(stp != 0 ? stopCnt == 1 : accessReady); k++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(startCnt == 1 && startRead == 0, "R1 start issued with write direction", startCnt, 1);
        check(sentCnt == n, "R3 bytes sent equals count", sentCnt, n);
        for (int b = 0; b < n; b++)
          check(sentLog[b] == 8'(16 * n + b + 1), "R3 byte order", int'(sentLog[b]), 16 * n + b + 1);
        if (stp != 0) begin
          check(stopCnt == 1 && !accessReady, "R6 stop issued, no access-ready", stopCnt, 1);
          check(ctrlQ[1] == 0 && int'(workCount) == n, "R6 stop bit cleared, count reloaded",
                int'(workCount), n);
        end else begin
          check(stopCnt == 0 && accessReady, "R7 access-ready without stop", int'(accessReady), 1);
          check(ctrlQ[10] == 0 && workCount == 0, "R7 master bit cleared", int'(ctrlQ[10]), 0);
        end
      end
    end

    // NACK position sweep
    for (int k = 0; k < 4; k++) begin
      clearLog(); nakAt = k; clrFlags(); cntWr(16'd4);
      ctrlWr(EN | MST | TRX | STT | STP);
      repeat (4) @(negedge clk);
      check(txReady == 1, "R3 txReady while count non-zero", int'(txReady), 1);
      for (int b = 0; b < 4; b++) push(8'(b + 8'h50));
      for (int w = 0; w < 300 && !nackFlag; w++) @(negedge clk);
      repeat (4) @(negedge clk);
      check(sentCnt == k + 1, "R4 sending ends at nacked byte", sentCnt, k + 1);
      check(nackFlag && ctrlQ[1] == 0 && stopCnt == 0, "R4 nack set, stop cancelled", stopCnt, 0);
      check(int'(workCount) == 4 - k && !txReady, "R4 count holds acked bytes only",
            int'(workCount), 4 - k);
    end

    // START not acknowledged
    clearLog(); clrFlags(); startNak = 1; cntWr(16'd3);
    ctrlWr(EN | MST | TRX | STT | STP);
    repeat (6) @(negedge clk);
    check(nackFlag && ctrlQ[1] == 0 && ctrlQ[0] == 0, "R2 start nack flags", int'(ctrlQ[1:0]), 0);
    check(startCnt == 1 && sentCnt == 0 && stopCnt == 0 && !opValid, "R2 no data after start nack",
          sentCnt, 0);
    startNak = 0;

    // counted receive sweep without stop
    for (int n = 1; n <= 4; n++) begin
      clearLog(); clrFlags(); cntWr(16'(n));
      ctrlWr(EN | MST | STT);
      for (int k = 0; k < 300 && !accessReady; k++) @(negedge clk);
      repeat (2) @(negedge clk);
      check(startRead == 1, "R1 start issued with read direction", int'(startRead), 1);
      check(recvCnt == n && int'(bufFill) == n, "R5 received count", int'(bufFill), n);
      check(rxReady == 1, "R5 rxReady with data buffered", int'(rxReady), 1);
      for (int b = 0; b < n; b++) begin
        check(rxHead == 8'hA0 + 8'(b), "R5 receive order", int'(rxHead), 8'hA0 + b);
        @(negedge clk); rxPop = 1;
        @(negedge clk); rxPop = 0;
      end
      check(rxReady == 0 && bufFill == 0, "R5 rxReady drops when empty", int'(rxReady), 0);
    end

    // counted receive of 6 with stop, drained while running
    begin
      int got;
      got = 0;
      clearLog(); clrFlags(); cntWr(16'd6);
      ctrlWr(EN | MST | STT | STP);
      for (int k = 0; k < 600 && !(stopCnt == 1 && bufFill == 0 && !rxPop); k++) begin
        @(negedge clk);
        if (rxPop) rxPop = 0;
        else if (bufFill != 0) begin
          check(rxHead == 8'hA0 + 8'(got), "R5 streamed receive order", int'(rxHead), 8'hA0 + got);
          got++;
          rxPop = 1;
        end
      end
      rxPop = 0;
      check(got == 6 && recvCnt == 6, "R5 six bytes through four-byte buffer", got, 6);
      check(stopCnt == 1 && workCount == 6 && !accessReady, "R6 stop after receive", stopCnt, 1);
    end

    // repeat mode transmit: count ignored
    clearLog(); clrFlags(); cntWr(16'd1);
    ctrlWr(EN | MST | TRX | RM | STT);
    repeat (4) @(negedge clk);
    check(txReady == 1, "R8 repeat txReady on empty buffer", int'(txReady), 1);
    for (int b = 0; b < 3; b++) push(8'(8'h70 + b));
    for (int k = 0; k < 300 && sentCnt < 3; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sentCnt == 3 && workCount == 1, "R8 repeat sends all, count untouched", sentCnt, 3);
    check(txReady == 1 && stopCnt == 0 && !accessReady, "R8 repeat drained", int'(txReady), 1);
    check(sentLog[2] == 8'h72, "R8 repeat byte order", int'(sentLog[2]), 8'h72);
    ctrlWr(EN | MST | TRX | RM | STP);
    for (int k = 0; k < 100 && stopCnt == 0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(stopCnt == 1 && ctrlQ[1] == 0, "R8 repeat stop on request", stopCnt, 1);

    // repeat mode receive: fills to four
    clearLog(); clrFlags(); cntWr(16'd2);
    ctrlWr(EN | MST | RM | STT);
    repeat (30) @(negedge clk);
    check(recvCnt == 4 && bufFill == 4, "R8 repeat receive fills buffer", recvCnt, 4);
    check(rxReady == 1 && workCount == 2, "R8 repeat rxReady, count untouched", int'(workCount), 2);
    ctrlWr(EN | MST | RM | STP);
    for (int k = 0; k < 100 && stopCnt == 0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(stopCnt == 1 && recvCnt == 4, "R8 repeat receive stop", stopCnt, 1);

    // control mask and ten-bit-address block
    clearLog();
    ctrlWr(16'hFFFF);
    repeat (6) @(negedge clk);
    check(ctrlQ == 16'hCF87, "R9 control mask", int'(ctrlQ), 16'hCF87);
    check(startCnt == 0 && !opValid, "R9 ten-bit address blocks start", startCnt, 0);

    // legacy reset via enable clear
    check(bufFill == 4 && workCount == 2, "R10 state present before reset", int'(bufFill), 4);
    ctrlWr(16'h0000);
    @(negedge clk);
    check(ctrlQ == 0 && workCount == 0 && bufFill == 0, "R10 enable clear resets",
          int'(bufFill), 0);
    check(!nackFlag && !accessReady && !rxReady, "R10 flags reset", int'(nackFlag), 0);

    // busy gating
    clearLog(); clrFlags(); gate = 1; cntWr(16'd2);
    ctrlWr(EN | MST | TRX | STT | STP);
    push(8'h31); push(8'h32);
    repeat (20) @(negedge clk);
    check(sentCnt == 0 && bufFill == 2, "R11 no data while bus not busy", sentCnt, 0);
    gate = 0;
    for (int k = 0; k < 300 && stopCnt == 0; k++) @(negedge clk);
    check(sentCnt == 2 && stopCnt == 1, "R11 data resumes when busy", sentCnt, 2);

    summary();
    $finish;
  end
endmodule